// File: doc/BRIEF.md
# USART Receive Buffer with Error Status

This block holds characters delivered by a USART receive shifter until software reads them. Each completed character arrives as a one-cycle strobe carrying its data and two tags, one for a bad stop bit (frame error) and one for a parity mismatch. Characters are kept in a small first-in first-out store of `DEPTH` entries (two by default). The oldest one is always presented on the read port. A receive-ready flag tells software that unread data is waiting.

Three sticky status bits report frame errors, parity errors and lost characters. Software clears them by writing ones to their positions. Overflow can be reported in one of two ways. In immediate mode the overflow bit rises as soon as a character is lost. In deferred mode the loss is remembered on the newest stored entry, and it surfaces only when software reads that entry, so the report lines up with the point in the data stream where the gap sits. Dropping the receiver enable empties the store and clears every status bit.

Top module: `usart_rxbuf`

## Requirements
- R1: Accepted characters are returned in arrival order. `rd_data` always shows the oldest unread character, and a `rd_en` pulse while data is waiting removes that character at the clock edge.
- R2: `rx_ready` is high exactly when at least one unread character is held. A `rd_en` pulse while the buffer is empty has no effect.
- R3: A character that arrives while all `DEPTH` entries are full, with no read in the same cycle, is discarded and the stored characters stay unchanged. If a read happens in the same cycle, the arriving character is accepted.
- R4: While `rx_en` is low, the next clock edge empties the buffer and clears all three status bits. Incoming characters and reads are ignored until `rx_en` returns high.
- R5: The frame-error and parity-error tags are stored with each character. The matching status bit is set at the clock edge after that character becomes the oldest entry. For a character written into an empty buffer, that is the second edge after it is captured.
- R6: A cycle with `sts_wr` high clears each status bit whose `sts_wdata` position holds 1: bit 0 frame error, bit 1 parity error, bit 2 overflow. Positions holding 0 leave their bit unchanged.
- R7: If a status bit is set and cleared by a write in the same cycle, the bit ends up set.
- R8: With `imm_ovf_mode` high, `sts_ovf` is set at the same clock edge that discards a character.
- R9: With `imm_ovf_mode` low, discarding a character does not change `sts_ovf`. Instead, the newest stored character is marked, and `sts_ovf` is set at the edge where that marked character is read.
- R10: Once set, a status bit stays set until a write-one clear or a receiver disable clears it, whatever reads and writes of data take place meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; low flushes the buffer and clears the status bits |
| imm_ovf_mode | input | 1 | 1: report overflow immediately; 0: report it when the marked character is read |
| chr_valid | input | 1 | One-cycle strobe for a completed character |
| chr_data | input | DATA_W | Character data |
| chr_ferr | input | 1 | Frame-error tag of the character |
| chr_perr | input | 1 | Parity-error tag of the character |
| rd_en | input | 1 | Read strobe; removes the oldest character |
| rd_data | output | DATA_W | Oldest unread character |
| rx_ready | output | 1 | Unread data present |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 3 | Write-one-to-clear mask: [0] frame, [1] parity, [2] overflow |
| sts_ferr | output | 1 | Sticky frame-error status |
| sts_perr | output | 1 | Sticky parity-error status |
| sts_ovf | output | 1 | Sticky overflow status |

## Verification
The bench builds the block with its defaults, `DATA_W` = 8 and `DEPTH` = 2. With that depth, the third back-to-back character already reaches the overflow path, so the bench can cover both overflow modes in a few cycles. The same small depth lets it sweep every combination of the two error tags, every one of the eight clear masks against a fully set status word, and the boundary cases: a read in the same cycle as an arrival to a full buffer, and a read of an empty buffer. Expected status words are formed in the bench from the tag bits and the clear mask with plain bit arithmetic.

// File: rtl/usart_rxbuf_pkg.sv
package usart_rxbuf_pkg;

  typedef struct packed {
    logic ferr;
    logic perr;
    logic ovf;
  } rxb_tag_t;

  localparam int unsigned STS_W     = 3;
  localparam int unsigned STS_FERR  = 0;
  localparam int unsigned STS_PERR  = 1;
  localparam int unsigned STS_OVF   = 2;

  function automatic int wrap_inc(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic int wrap_dec(input int p, input int depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

endpackage

// File: rtl/usart_rxbuf_fifo.sv
module usart_rxbuf_fifo
  import usart_rxbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_ferr,
  input  logic              push_perr,
  input  logic              tag_ovf_en,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head_data,
  output rxb_tag_t          head_tag,
  output logic              not_empty,
  output logic              push_done,
  output logic              pop_done,
  output logic              dropped,
  output logic              head_fresh
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  rxb_tag_t          tags [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;
  logic              full;
  logic              fresh_d;
  logic [PW-1:0]     wr_nxt, rd_nxt, newest;

  assign full      = (cnt == FULL_CNT);
  assign not_empty = (cnt != '0);
  assign pop_done  = pop_req && not_empty;
  assign push_done = push_req && (!full || pop_done);
  assign dropped   = push_req && full && !pop_done;

  assign wr_nxt = PW'(wrap_inc(int'(wr_ptr), int'(DEPTH)));
  assign rd_nxt = PW'(wrap_inc(int'(rd_ptr), int'(DEPTH)));
  assign newest = PW'(wrap_dec(int'(wr_ptr), int'(DEPTH)));

  assign head_data = mem[rd_ptr];
  assign head_tag  = tags[rd_ptr];

  // A new entry reaches the head when written into an empty store, when
  // written while the only stored entry leaves, or when a pop exposes the next.
  always_comb begin
    fresh_d = 1'b0;
    if (push_done && (cnt == '0 || (pop_done && cnt == CW'(1))))
      fresh_d = 1'b1;
    if (pop_done && cnt > CW'(1))
      fresh_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      cnt        <= '0;
      head_fresh <= 1'b0;
      for (int i = 0; i < int'(DEPTH); i++) begin
        mem[i]  <= '0;
        tags[i] <= '0;
      end
    end else if (flush) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      cnt        <= '0;
      head_fresh <= 1'b0;
      for (int i = 0; i < int'(DEPTH); i++) tags[i] <= '0;
    end else begin
      head_fresh <= fresh_d;
      if (push_done) begin
        mem[wr_ptr]  <= push_data;
        tags[wr_ptr] <= '{ferr: push_ferr, perr: push_perr, ovf: 1'b0};
        wr_ptr       <= wr_nxt;
      end
      if (dropped && tag_ovf_en)
        tags[newest].ovf <= 1'b1;
      if (pop_done)
        rd_ptr <= rd_nxt;
      if (push_done && !pop_done)
        cnt <= cnt + CW'(1);
      else if (pop_done && !push_done)
        cnt <= cnt - CW'(1);
    end
  end

endmodule

// File: rtl/usart_rxbuf_sticky.sv
module usart_rxbuf_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  logic set_evt,
  input  logic wr_clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (clr_all) q <= 1'b0;
    else if (set_evt) q <= 1'b1;
    else if (wr_clr)  q <= 1'b0;
  end

endmodule

// File: rtl/usart_rxbuf.sv
module usart_rxbuf
  import usart_rxbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              imm_ovf_mode,
  input  logic              chr_valid,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              chr_ferr,
  input  logic              chr_perr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_ready,
  input  logic              sts_wr,
  input  logic [2:0]        sts_wdata,
  output logic              sts_ferr,
  output logic              sts_perr,
  output logic              sts_ovf
);

  logic             flush;
  logic             push_req, pop_req;
  rxb_tag_t         head_tag;
  logic             push_done, pop_done, fifo_drop, head_fresh;
  logic             set_ferr, set_perr, set_ovf;
  logic [STS_W-1:0] set_vec, clr_vec, sts_q;

  assign flush    = !rx_en;
  assign push_req = rx_en && chr_valid;
  assign pop_req  = rx_en && rd_en;

  usart_rxbuf_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .push_req   (push_req),
    .push_data  (chr_data),
    .push_ferr  (chr_ferr),
    .push_perr  (chr_perr),
    .tag_ovf_en (!imm_ovf_mode),
    .pop_req    (pop_req),
    .head_data  (rd_data),
    .head_tag   (head_tag),
    .not_empty  (rx_ready),
    .push_done  (push_done),
    .pop_done   (pop_done),
    .dropped    (fifo_drop),
    .head_fresh (head_fresh)
  );

  // Named status events
  assign set_ferr = head_fresh && head_tag.ferr;
  assign set_perr = head_fresh && head_tag.perr;
  assign set_ovf  = (imm_ovf_mode && fifo_drop) || (pop_done && head_tag.ovf);

  always_comb begin
    set_vec           = '0;
    set_vec[STS_FERR] = set_ferr;
    set_vec[STS_PERR] = set_perr;
    set_vec[STS_OVF]  = set_ovf;
    clr_vec           = sts_wr ? sts_wdata : '0;
  end

  for (genvar g = 0; g < int'(STS_W); g++) begin : g_sts
    usart_rxbuf_sticky u_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (flush),
      .set_evt (set_vec[g]),
      .wr_clr  (clr_vec[g]),
      .q       (sts_q[g])
    );
  end

  assign sts_ferr = sts_q[STS_FERR];
  assign sts_perr = sts_q[STS_PERR];
  assign sts_ovf  = sts_q[STS_OVF];

endmodule

// File: rtl/usart_rxbuf_chk.sv
module usart_rxbuf_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              imm_ovf_mode,
  input logic              chr_valid,
  input logic              sts_wr,
  input logic [2:0]        sts_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              rx_ready,
  input logic              sts_ferr,
  input logic              sts_perr,
  input logic              sts_ovf,
  input logic              fifo_drop,
  input logic              set_ferr
);

  // R2: an empty buffer with no arrival stays empty
  p_stay_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && !rx_ready && !chr_valid |=> !rx_ready);

  // R3: a dropped character leaves the head untouched
  p_drop_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && fifo_drop |=> rx_ready && $stable(rd_data));

  // R4: disable flushes data and status
  p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_ready && !sts_ferr && !sts_perr && !sts_ovf);

  // R7: a set event wins over a same-cycle clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && set_ferr |=> sts_ferr);

  // R8: immediate mode reports a drop at once
  p_imm_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && imm_ovf_mode && fifo_drop |=> sts_ovf);

  // R9: deferred mode leaves the overflow bit alone on the drop itself
  p_defer_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && !imm_ovf_mode && fifo_drop && !sts_wr |=> $stable(sts_ovf));

  // R10: a set bit holds without a matching clear
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && sts_perr && !(sts_wr && sts_wdata[1]) |=> sts_perr);

endmodule

bind usart_rxbuf usart_rxbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_en        (rx_en),
  .imm_ovf_mode (imm_ovf_mode),
  .chr_valid    (chr_valid),
  .sts_wr       (sts_wr),
  .sts_wdata    (sts_wdata),
  .rd_data      (rd_data),
  .rx_ready     (rx_ready),
  .sts_ferr     (sts_ferr),
  .sts_perr     (sts_perr),
  .sts_ovf      (sts_ovf),
  .fifo_drop    (fifo_drop),
  .set_ferr     (set_ferr)
);

// File: tb/test_usart_rxbuf.sv
`timescale 1ns/1ps
module test_usart_rxbuf;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b0;
  logic          imm_ovf_mode = 1'b1;
  logic          chr_valid = 1'b0;
  logic [DW-1:0] chr_data = '0;
  logic          chr_ferr = 1'b0;
  logic          chr_perr = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rx_ready;
  logic          sts_wr = 1'b0;
  logic [2:0]    sts_wdata = '0;
  logic          sts_ferr, sts_perr, sts_ovf;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usart_rxbuf #(.DATA_W(DW), .DEPTH(2)) i_usart_rxbuf (
    .clk, .rst_n, .rx_en, .imm_ovf_mode, .chr_valid, .chr_data,
    .chr_ferr, .chr_perr, .rd_en, .rd_data, .rx_ready,
    .sts_wr, .sts_wdata, .sts_ferr, .sts_perr, .sts_ovf
  );

  function automatic logic [2:0] flags();
    return {sts_ovf, sts_perr, sts_ferr};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d, input logic f, input logic p);
    chr_valid = 1'b1; chr_data = d; chr_ferr = f; chr_perr = p;
    tick();
    chr_valid = 1'b0; chr_ferr = 1'b0; chr_perr = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic wr_sts(input logic [2:0] m);
    sts_wr = 1'b1; sts_wdata = m;
    tick();
    sts_wr = 1'b0; sts_wdata = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    check("R2 reset ready", rx_ready, 0);
    check("R10 reset status", flags(), 0);
    rx_en = 1'b1;
    tick();

    // R5 / R1: sweep both tags on a character written to an empty buffer
    for (int t = 0; t < 4; t++) begin
      push(DW'(8'hA0 + t), t[0], t[1]);
      check("R2 ready after write", rx_ready, 1);
      check("R1 head data", rd_data, 8'hA0 + t);
      check("R5 not yet set", flags(), 0);
      tick();
      check("R5 tag status", flags(), {1'b0, t[1], t[0]});
      pop();
      check("R2 empty after read", rx_ready, 0);
      wr_sts(3'b111);
      check("R6 clear all", flags(), 0);
    end

    // R8 / R3 / R10 / R6: fill, overflow immediately, sweep clear masks
    imm_ovf_mode = 1'b1;
    for (int m = 0; m < 8; m++) begin
      push(8'h10, 1'b1, 1'b1);
      push(8'h11, 1'b1, 1'b1);
      push(8'h12, 1'b0, 1'b0);
      check("R8 immediate overflow", flags(), 3'b111);
      check("R3 head kept", rd_data, 8'h10);
      pop();
      check("R1 second entry", rd_data, 8'h11);
      pop();
      check("R3 dropped char absent", rx_ready, 0);
      check("R10 sticky after reads", flags(), 3'b111);
      wr_sts(3'(m));
      check("R6 masked clear", flags(), 3'b111 & ~3'(m));
      wr_sts(3'b111);
    end

    // R7: set and clear in the same cycle
    push(8'h20, 1'b1, 1'b0);
    wr_sts(3'b001);
    check("R7 set wins", sts_ferr, 1);
    wr_sts(3'b001);
    check("R6 later clear", sts_ferr, 0);
    pop();

    // R2: reading an empty buffer
    pop();
    check("R2 empty read", rx_ready, 0);
    push(8'h21, 1'b0, 1'b0);
    check("R2 write after empty read", rd_data, 8'h21);
    pop();

    // R9: deferred overflow
    imm_ovf_mode = 1'b0;
    push(8'hC0, 1'b0, 1'b0);
    push(8'hC1, 1'b0, 1'b0);
    push(8'hC2, 1'b0, 1'b0);
    check("R9 no flag at drop", sts_ovf, 0);
    check("R3 head kept deferred", rd_data, 8'hC0);
    pop();
    check("R9 no flag on unmarked read", sts_ovf, 0);
    check("R9 marked entry next", rd_data, 8'hC1);
    pop();
    check("R9 flag on marked read", sts_ovf, 1);
    check("R9 buffer empty", rx_ready, 0);
    wr_sts(3'b100);
    check("R6 clear ovf", sts_ovf, 0);

    // R3: arrival to a full buffer with a read in the same cycle
    imm_ovf_mode = 1'b1;
    push(8'hE0, 1'b0, 1'b0);
    push(8'hE1, 1'b0, 1'b0);
    chr_valid = 1'b1; chr_data = 8'hE2; rd_en = 1'b1;
    tick();
    chr_valid = 1'b0; rd_en = 1'b0;
    check("R3 no overflow with read", sts_ovf, 0);
    check("R3 head after read", rd_data, 8'hE1);
    pop();
    check("R3 accepted char", rd_data, 8'hE2);
    pop();
    check("R2 drained", rx_ready, 0);

    // R4: disable flushes and clears
    push(8'hF0, 1'b1, 1'b0);
    push(8'hF1, 1'b0, 1'b1);
    tick();
    check("R5 ferr before disable", sts_ferr, 1);
    rx_en = 1'b0;
    tick();
    check("R4 flush ready", rx_ready, 0);
    check("R4 flush status", flags(), 0);
    push(8'hF2, 1'b1, 1'b1);
    tick();
    check("R4 ignored while off", rx_ready, 0);
    check("R4 status while off", flags(), 0);
    rx_en = 1'b1;
    tick();
    check("R4 empty after enable", rx_ready, 0);
    push(8'hF3, 1'b0, 1'b0);
    check("R4 fresh data", rd_data, 8'hF3);
    pop();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule